// File: doc/BRIEF.md
# Processor Debug Event Recorder

This block sits beside a simple in-order core and turns debug-relevant happenings into sticky status flags and a debug interrupt request. Two kinds of source feed it. Instruction-caused events come from decoded strobes for "return from interrupt" and "return from critical interrupt", each with the address of the instruction. Pin-caused events come from three pins of asynchronous origin: two external debug event pins and one unconditional event pin. Every pin passes through a synchronizer and an edge detector, so holding a pin high produces one event only.

Events are logged whatever the machine-state debug-enable bit says. If an instruction event cannot be taken because debug interrupts are off and no external debugger owns the block, an imprecise-event flag records that fact. When debug interrupts are on, the instruction address is saved and an interrupt is requested. A three-state request machine holds the request back while a higher-priority exception is pending. Software reads and writes the registers through a small port. An external debugger has its own write port. It sets the external-debug-mode bit and a per-resource ownership mask, and software writes to fields that the debugger owns are dropped without effect.

Top module: `dbg_event_rec`

## Requirements
- R1: After reset the control, status, save and ownership registers read 0 and `dbg_irq` is 0.
- R2: A `ret_v` strobe sets status bit 0 and a `cret_v` strobe sets status bit 1, each on the clock edge that samples the strobe, and only when the matching control enable (control bit 0 for return, bit 1 for critical return) is 1. This happens whatever the value of `dbg_en`. With its enable at 0, a strobe leaves status unchanged.
- R3: When a recorded return or critical-return event occurs while `dbg_en` is 0 and the external-debug-mode bit (control bit 5) is 0, status bit 5 (imprecise) is also set. Both bits are sampled before that edge.
- R4: When a recorded instruction event occurs with `dbg_en` at 1, the save register is loaded with that instruction's address. If both strobes are recorded in one cycle, the critical-return address is kept. Pin events never load it.
- R5: External pin 1 (`xevt1`) sets status bit 2 when control bit 2 is 1, and pin 2 (`xevt2`) sets status bit 3 when control bit 3 is 1. Each event fires once per low-to-high transition of the pin. The bit is set on the third rising clock edge counted from the first edge that sees the pin high.
- R6: The unconditional pin (`uevt`) sets status bit 4 on its low-to-high transition, with the same latency as R5, when control bit 4 (internal debug mode) or control bit 5 (external debug mode) is 1. It has no enable bit of its own.
- R7: `dbg_irq` is a register. It is 1 in the cycle after an edge at which `dbg_en` is 1, `hp_pend` is 0, and at least one of status bits 0..4 is set with its qualifier. The qualifier for bits 0..3 is control bits 0..3, and for bit 4 it is (control bit 4 OR control bit 5). Otherwise it is 0. The request machine has three states. IDLE goes to REQ when a request is wanted and no higher exception is pending. IDLE goes to HELD when a request is wanted but a higher exception is pending. REQ goes to HELD on a pending exception. HELD goes back to REQ when it clears. REQ or HELD goes to IDLE when the request is no longer wanted.
- R8: Status bits are sticky. A software write to status clears each bit written as 1 (write-one-to-clear). An event on the same edge wins over the clear.
- R9: While control bit 5 is 1, a software write to a resource whose ownership bit is 0 has no effect. Ownership bit 0 covers control, bit 1 covers status and bit 2 covers the save register. Software never changes control bit 5 or the ownership register. Only the debugger port (`dp_we`, `dp_addr` 0 = control, 3 = ownership) writes them, and it wins over a software write in the same cycle.
- R10: The address map for `sw_addr` and `dp_addr` is 0 = control (6 bits), 1 = status (6 bits), 2 = save (`ADDR_W` bits), 3 = ownership (3 bits). `sw_rdata` returns the addressed register zero-extended, combinationally from `sw_addr`.
- R11: Events that occur on the same edge all set their status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_v | input | 1 | Return-from-interrupt instruction strobe |
| ret_addr | input | ADDR_W | Address of the return instruction |
| cret_v | input | 1 | Return-from-critical-interrupt instruction strobe |
| cret_addr | input | ADDR_W | Address of the critical return instruction |
| xevt1 | input | 1 | External debug event pin 1 (asynchronous) |
| xevt2 | input | 1 | External debug event pin 2 (asynchronous) |
| uevt | input | 1 | Unconditional debug event pin (asynchronous) |
| dbg_en | input | 1 | Debug-interrupt enable from machine state |
| hp_pend | input | 1 | Higher-priority enabled exception pending |
| sw_we | input | 1 | Software write strobe |
| sw_addr | input | 2 | Software register address |
| sw_wdata | input | ADDR_W | Software write data |
| sw_rdata | output | ADDR_W | Software read data |
| dp_we | input | 1 | Debugger-port write strobe |
| dp_addr | input | 2 | Debugger-port register address |
| dp_wdata | input | 6 | Debugger-port write data |
| dbg_irq | output | 1 | Debug interrupt request |

## Verification
Some properties are checked on every cycle: a critical-return strobe with its enable set is always recorded, the imprecise flag always follows a strobe that cannot be taken, and the save register always takes the critical-return address when debug is enabled. The status bits never drop without a software status write. The pin-caused bits only rise when their qualifier held. The request is only raised after debug was enabled with no higher exception pending. Some behaviour only the scenarios can show, because it needs history or exact timing. This covers the once-per-assertion pin behaviour over a long high level, the three-edge synchronizer latency, and set-beats-clear on a shared edge. It also covers the HELD-to-REQ release when the pending exception goes away, and the full ownership matrix against both write ports.

// File: rtl/dbg_rec_pkg.sv
package dbg_rec_pkg;

    localparam int CTL_W  = 6;
    localparam int STAT_W = 6;
    localparam int OWN_W  = 3;
    localparam int PIN_N  = 3;

    // control bit positions
    localparam int C_RET  = 0;
    localparam int C_CRET = 1;
    localparam int C_EXT1 = 2;
    localparam int C_EXT2 = 3;
    localparam int C_IDM  = 4;
    localparam int C_EDM  = 5;

    // status bit positions
    localparam int S_RET  = 0;
    localparam int S_CRET = 1;
    localparam int S_EXT1 = 2;
    localparam int S_EXT2 = 3;
    localparam int S_UNC  = 4;
    localparam int S_IMP  = 5;

    // ownership bit positions
    localparam int O_CTRL = 0;
    localparam int O_STAT = 1;
    localparam int O_SAVE = 2;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_SAVE = 2'd2,
        RA_OWN  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        IRQ_IDLE = 2'd0,
        IRQ_REQ  = 2'd1,
        IRQ_HELD = 2'd2
    } irq_state_e;

endpackage

// File: rtl/dbg_pin_edge.sv
module dbg_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    localparam int CHAIN_W = STAGES + 1;

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], pin};
        end
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/dbg_irq_fsm.sv
module dbg_irq_fsm
    import dbg_rec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic hp_pend,
    output logic irq
);

    irq_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= IRQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_IDLE: begin
                if (want) begin
                    st_d = hp_pend ? IRQ_HELD : IRQ_REQ;
                end
            end
            IRQ_REQ: begin
                if (!want) begin
                    st_d = IRQ_IDLE;
                end else if (hp_pend) begin
                    st_d = IRQ_HELD;
                end
            end
            IRQ_HELD: begin
                if (!want) begin
                    st_d = IRQ_IDLE;
                end else if (!hp_pend) begin
                    st_d = IRQ_REQ;
                end
            end
            default: st_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (st_q == IRQ_REQ);
    end

endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
    import dbg_rec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_we,
    input  logic [1:0]          sw_addr,
    input  logic [ADDR_W-1:0]   sw_wdata,
    input  logic                dp_we,
    input  logic [1:0]          dp_addr,
    input  logic [CTL_W-1:0]    dp_wdata,
    input  logic [STAT_W-1:0]   ev_set,
    input  logic                save_ld,
    input  logic [ADDR_W-1:0]   save_val,
    output logic [CTL_W-1:0]    ctrl_o,
    output logic [STAT_W-1:0]   stat_o,
    output logic [ADDR_W-1:0]   save_o,
    output logic [OWN_W-1:0]    own_o,
    output logic [ADDR_W-1:0]   rdata_o
);

    logic [CTL_W-1:0]  ctrl_q;
    logic [STAT_W-1:0] stat_q;
    logic [ADDR_W-1:0] save_q;
    logic [OWN_W-1:0]  own_q;

    reg_addr_e sw_sel, dp_sel;
    logic      sw_free_ctrl, sw_free_stat, sw_free_save;
    logic      sw_hit_ctrl, sw_hit_stat, sw_hit_save;
    logic      dp_hit_ctrl, dp_hit_own;
    logic [STAT_W-1:0] clr_mask;

    assign sw_sel = reg_addr_e'(sw_addr);
    assign dp_sel = reg_addr_e'(dp_addr);

    // software may write a resource unless the debugger owns the block and not this field
    assign sw_free_ctrl = ~ctrl_q[C_EDM] | own_q[O_CTRL];
    assign sw_free_stat = ~ctrl_q[C_EDM] | own_q[O_STAT];
    assign sw_free_save = ~ctrl_q[C_EDM] | own_q[O_SAVE];

    assign sw_hit_ctrl = sw_we && (sw_sel == RA_CTRL) && sw_free_ctrl;
    assign sw_hit_stat = sw_we && (sw_sel == RA_STAT) && sw_free_stat;
    assign sw_hit_save = sw_we && (sw_sel == RA_SAVE) && sw_free_save;
    assign dp_hit_ctrl = dp_we && (dp_sel == RA_CTRL);
    assign dp_hit_own  = dp_we && (dp_sel == RA_OWN);

    assign clr_mask = sw_hit_stat ? sw_wdata[STAT_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (dp_hit_ctrl) begin
            ctrl_q <= dp_wdata;
        end else if (sw_hit_ctrl) begin
            ctrl_q <= {ctrl_q[C_EDM], sw_wdata[C_EDM-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | ev_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            save_q <= '0;
        end else if (save_ld) begin
            save_q <= save_val;
        end else if (sw_hit_save) begin
            save_q <= sw_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= '0;
        end else if (dp_hit_own) begin
            own_q <= dp_wdata[OWN_W-1:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (sw_sel)
            RA_CTRL: rdata_o = ADDR_W'(ctrl_q);
            RA_STAT: rdata_o = ADDR_W'(stat_q);
            RA_SAVE: rdata_o = save_q;
            RA_OWN:  rdata_o = ADDR_W'(own_q);
            default: rdata_o = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign stat_o = stat_q;
    assign save_o = save_q;
    assign own_o  = own_q;

endmodule

// File: rtl/dbg_event_rec.sv
module dbg_event_rec
    import dbg_rec_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ret_v,
    input  logic [ADDR_W-1:0]   ret_addr,
    input  logic                cret_v,
    input  logic [ADDR_W-1:0]   cret_addr,
    input  logic                xevt1,
    input  logic                xevt2,
    input  logic                uevt,
    input  logic                dbg_en,
    input  logic                hp_pend,
    input  logic                sw_we,
    input  logic [1:0]          sw_addr,
    input  logic [ADDR_W-1:0]   sw_wdata,
    output logic [ADDR_W-1:0]   sw_rdata,
    input  logic                dp_we,
    input  logic [1:0]          dp_addr,
    input  logic [CTL_W-1:0]    dp_wdata,
    output logic                dbg_irq
);

    localparam int CAUSE_W = STAT_W - 1;

    logic [PIN_N-1:0]   pins, rise;
    logic [CTL_W-1:0]   ctrl_q;
    logic [STAT_W-1:0]  stat_q;
    logic [ADDR_W-1:0]  save_q;
    logic [OWN_W-1:0]   own_q;
    logic [STAT_W-1:0]  ev_set;
    logic [CAUSE_W-1:0] cause_mask;
    logic               insn_ev, save_ld, irq_want, dbg_mode;
    logic [ADDR_W-1:0]  save_val;

    assign pins = {uevt, xevt2, xevt1};

    for (genvar gi = 0; gi < PIN_N; gi++) begin : g_pin
        dbg_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pins[gi]),
            .rise  (rise[gi])
        );
    end

    assign dbg_mode = ctrl_q[C_IDM] | ctrl_q[C_EDM];

    always_comb begin
        ev_set         = '0;
        ev_set[S_RET]  = ret_v   & ctrl_q[C_RET];
        ev_set[S_CRET] = cret_v  & ctrl_q[C_CRET];
        ev_set[S_EXT1] = rise[0] & ctrl_q[C_EXT1];
        ev_set[S_EXT2] = rise[1] & ctrl_q[C_EXT2];
        ev_set[S_UNC]  = rise[2] & dbg_mode;
        ev_set[S_IMP]  = (ev_set[S_RET] | ev_set[S_CRET]) & ~dbg_en & ~ctrl_q[C_EDM];
    end

    assign insn_ev  = ev_set[S_RET] | ev_set[S_CRET];
    assign save_ld  = insn_ev & dbg_en;
    assign save_val = ev_set[S_CRET] ? cret_addr : ret_addr;

    assign cause_mask = {dbg_mode, ctrl_q[C_EXT2:C_RET]};
    assign irq_want   = dbg_en & (|(stat_q[CAUSE_W-1:0] & cause_mask));

    dbg_reg_bank #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (sw_we),
        .sw_addr  (sw_addr),
        .sw_wdata (sw_wdata),
        .dp_we    (dp_we),
        .dp_addr  (dp_addr),
        .dp_wdata (dp_wdata),
        .ev_set   (ev_set),
        .save_ld  (save_ld),
        .save_val (save_val),
        .ctrl_o   (ctrl_q),
        .stat_o   (stat_q),
        .save_o   (save_q),
        .own_o    (own_q),
        .rdata_o  (sw_rdata)
    );

    dbg_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .want    (irq_want),
        .hp_pend (hp_pend),
        .irq     (dbg_irq)
    );

endmodule

// File: rtl/dbg_event_rec_chk.sv
module dbg_event_rec_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ret_v,
    input logic              cret_v,
    input logic [ADDR_W-1:0] cret_addr,
    input logic              dbg_en,
    input logic              hp_pend,
    input logic              sw_we,
    input logic [1:0]        sw_addr,
    input logic              dp_we,
    input logic              dbg_irq,
    input logic [5:0]        ctrl_q,
    input logic [5:0]        stat_q,
    input logic [ADDR_W-1:0] save_q,
    input logic [2:0]        own_q
);

    AST_CRET_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        (cret_v && ctrl_q[1]) |=> stat_q[1]); // R2

    AST_IMPRECISE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_v && ctrl_q[0] && !dbg_en && !ctrl_q[5]) |=> stat_q[5]); // R3

    AST_SAVE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cret_v && ctrl_q[1] && dbg_en) |=> (save_q == $past(cret_addr))); // R4

    AST_EXT1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[2]) |-> $past(ctrl_q[2])); // R5

    AST_UNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[4]) |-> $past(ctrl_q[4] || ctrl_q[5])); // R6

    AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_irq |-> $past(dbg_en && !hp_pend)); // R7

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_we && sw_addr == 2'd1) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R8

    AST_CTRL_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[5] && !own_q[0] && sw_we && sw_addr == 2'd0 && !dp_we) |=> $stable(ctrl_q)); // R9

endmodule

bind dbg_event_rec dbg_event_rec_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_v     (ret_v),
    .cret_v    (cret_v),
    .cret_addr (cret_addr),
    .dbg_en    (dbg_en),
    .hp_pend   (hp_pend),
    .sw_we     (sw_we),
    .sw_addr   (sw_addr),
    .dp_we     (dp_we),
    .dbg_irq   (dbg_irq),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q),
    .save_q    (save_q),
    .own_q     (own_q)
);

// File: tb/dbg_event_rec_tb.sv
`timescale 1ns/1ps
module dbg_event_rec_tb;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ret_v = 1'b0, cret_v = 1'b0;
    logic [AW-1:0] ret_addr = '0, cret_addr = '0;
    logic          xevt1 = 1'b0, xevt2 = 1'b0, uevt = 1'b0;
    logic          dbg_en = 1'b0, hp_pend = 1'b0;
    logic          sw_we = 1'b0;
    logic [1:0]    sw_addr = 2'd0;
    logic [AW-1:0] sw_wdata = '0;
    logic [AW-1:0] sw_rdata;
    logic          dp_we = 1'b0;
    logic [1:0]    dp_addr = 2'd0;
    logic [5:0]    dp_wdata = '0;
    logic          dbg_irq;

    dbg_event_rec #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ret_v(ret_v), .ret_addr(ret_addr),
        .cret_v(cret_v), .cret_addr(cret_addr), .xevt1(xevt1), .xevt2(xevt2),
        .uevt(uevt), .dbg_en(dbg_en), .hp_pend(hp_pend), .sw_we(sw_we),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .dp_we(dp_we), .dp_addr(dp_addr), .dp_wdata(dp_wdata), .dbg_irq(dbg_irq)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [5:0]    m_ctrl, m_stat, m_ev, m_clr;
    logic [AW-1:0] m_save;
    logic [2:0]    m_own, m_s1, m_s2, m_s3, m_pl;
    logic          m_irq, m_edm;

    function automatic logic [AW-1:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    m_read = AW'(m_ctrl);
            2'd1:    m_read = AW'(m_stat);
            2'd2:    m_read = m_save;
            default: m_read = AW'(m_own);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_stat = '0; m_save = '0; m_own = '0; m_irq = 1'b0;
            m_s1 = '0; m_s2 = '0; m_s3 = '0;
        end else begin
            m_pl = m_s2 & ~m_s3;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = {uevt, xevt2, xevt1};
            m_edm = m_ctrl[5];
            m_ev = '0;
            m_ev[0] = ret_v & m_ctrl[0];
            m_ev[1] = cret_v & m_ctrl[1];
            m_ev[2] = m_pl[0] & m_ctrl[2];
            m_ev[3] = m_pl[1] & m_ctrl[3];
            m_ev[4] = m_pl[2] & (m_ctrl[4] | m_edm);
            m_ev[5] = (m_ev[0] | m_ev[1]) & ~dbg_en & ~m_edm;
            m_irq = dbg_en & ~hp_pend & (|(m_stat[4:0] & {m_ctrl[4] | m_edm, m_ctrl[3:0]}));
            m_clr = (sw_we && sw_addr == 2'd1 && (!m_edm || m_own[1])) ? sw_wdata[5:0] : 6'd0;
            m_stat = (m_stat & ~m_clr) | m_ev;
            if ((m_ev[0] | m_ev[1]) && dbg_en)
                m_save = m_ev[1] ? cret_addr : ret_addr;
            else if (sw_we && sw_addr == 2'd2 && (!m_edm || m_own[2]))
                m_save = sw_wdata;
            if (dp_we && dp_addr == 2'd0)
                m_ctrl = dp_wdata;
            else if (sw_we && sw_addr == 2'd0 && (!m_edm || m_own[0]))
                m_ctrl = {m_edm, sw_wdata[4:0]};
            if (dp_we && dp_addr == 2'd3)
                m_own = dp_wdata[2:0];
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("R7 irq vs model", AW'(dbg_irq), AW'(m_irq));
            chk("R10 rdata vs model", sw_rdata, m_read(sw_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_wr(input logic [1:0] a, input logic [AW-1:0] d);
        @(negedge clk); sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk); sw_we = 1'b0;
    endtask

    task automatic dp_wr(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk); dp_we = 1'b1; dp_addr = a; dp_wdata = d;
        @(negedge clk); dp_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input logic [AW-1:0] exp);
        @(negedge clk); sw_addr = a; #1;
        chk(tag, sw_rdata, exp);
    endtask

    task automatic ret_strobe(input logic [AW-1:0] a);
        @(negedge clk); ret_v = 1'b1; ret_addr = a;
        @(negedge clk); ret_v = 1'b0;
    endtask

    task automatic cret_strobe(input logic [AW-1:0] a);
        @(negedge clk); cret_v = 1'b1; cret_addr = a;
        @(negedge clk); cret_v = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, "R1 ctrl after reset", 32'h0);
        rd(2'd1, "R1 stat after reset", 32'h0);
        rd(2'd2, "R1 save after reset", 32'h0);
        rd(2'd3, "R1 own after reset", 32'h0);
        chk("R1 irq after reset", AW'(dbg_irq), 32'h0);

        // R2/R3: return recorded with debug disabled, imprecise flagged, no save
        sw_wr(2'd0, 32'h03);
        ret_strobe(32'h100);
        rd(2'd1, "R2 R3 ret with de=0", 32'h21);
        rd(2'd2, "R4 no capture with de=0", 32'h0);
        sw_wr(2'd1, 32'h3F);
        rd(2'd1, "R8 w1c clears all", 32'h0);

        // R2: disabled return has no effect
        sw_wr(2'd0, 32'h02);
        ret_strobe(32'h104);
        rd(2'd1, "R2 disabled ret ignored", 32'h0);

        // R4/R7: critical return with de=1 and higher exception pending
        dbg_en = 1'b1; hp_pend = 1'b1;
        cret_strobe(32'h2468);
        rd(2'd1, "R3 no imprecise when de=1", 32'h02);
        rd(2'd2, "R4 save holds cret addr", 32'h2468);
        cyc(1);
        chk("R7 irq held by hp_pend", AW'(dbg_irq), 32'h0);
        hp_pend = 1'b0;
        cyc(2);
        chk("R7 irq raised after hp clears", AW'(dbg_irq), 32'h1);
        sw_wr(2'd1, 32'h02);
        cyc(2);
        chk("R8 irq drops after clear", AW'(dbg_irq), 32'h0);

        // R11: both strobes in one cycle
        sw_wr(2'd0, 32'h03);
        @(negedge clk); ret_v = 1'b1; ret_addr = 32'h10; cret_v = 1'b1; cret_addr = 32'h20;
        @(negedge clk); ret_v = 1'b0; cret_v = 1'b0;
        rd(2'd1, "R11 both events recorded", 32'h03);
        rd(2'd2, "R4 cret address wins", 32'h20);
        dbg_en = 1'b0;
        sw_wr(2'd1, 32'h3F);

        // R8: event and clear on the same edge, event wins
        sw_wr(2'd0, 32'h01);
        @(negedge clk); ret_v = 1'b1; ret_addr = 32'h30; sw_we = 1'b1; sw_addr = 2'd1; sw_wdata = 32'h01;
        @(negedge clk); ret_v = 1'b0; sw_we = 1'b0;
        rd(2'd1, "R8 set beats clear", 32'h21);
        sw_wr(2'd1, 32'h3F);

        // R5: external pin 1 edge, once per assertion
        sw_wr(2'd0, 32'h04);
        @(negedge clk); xevt1 = 1'b1;
        cyc(1);
        rd(2'd1, "R5 not yet after two edges", 32'h0);
        rd(2'd1, "R5 set on third edge", 32'h04);
        sw_wr(2'd1, 32'h04);
        cyc(5);
        rd(2'd1, "R5 held level gives one event", 32'h0);
        xevt1 = 1'b0;
        @(negedge clk); xevt2 = 1'b1;
        cyc(5); xevt2 = 1'b0;
        rd(2'd1, "R5 pin 2 disabled ignored", 32'h0);

        // R6: unconditional event gated by debug modes only
        sw_wr(2'd0, 32'h00);
        @(negedge clk); uevt = 1'b1; cyc(5); uevt = 1'b0; cyc(2);
        rd(2'd1, "R6 no mode no event", 32'h0);
        sw_wr(2'd0, 32'h10);
        @(negedge clk); uevt = 1'b1; cyc(5); uevt = 1'b0; cyc(2);
        rd(2'd1, "R6 idm event recorded", 32'h10);
        sw_wr(2'd1, 32'h3F);

        // R9: ownership enforced while in external debug mode
        dp_wr(2'd0, 6'h20);
        sw_wr(2'd0, 32'h01);
        rd(2'd0, "R9 ctrl write dropped", 32'h20);
        sw_wr(2'd2, 32'h55);
        rd(2'd2, "R9 save write dropped", 32'h20);
        @(negedge clk); uevt = 1'b1; cyc(5); uevt = 1'b0; cyc(2);
        rd(2'd1, "R6 edm event recorded", 32'h10);
        sw_wr(2'd1, 32'h10);
        rd(2'd1, "R9 status clear dropped", 32'h10);
        dp_wr(2'd3, 6'h02);
        sw_wr(2'd1, 32'h10);
        rd(2'd1, "R9 owned status clears", 32'h0);
        sw_wr(2'd3, 32'h7);
        rd(2'd3, "R9 own not software writable", 32'h2);
        dp_wr(2'd0, 6'h21);
        ret_strobe(32'h40);
        rd(2'd1, "R3 no imprecise under edm", 32'h01);
        dp_wr(2'd3, 6'h07);
        sw_wr(2'd0, 32'h00);
        rd(2'd0, "R9 edm bit kept on sw write", 32'h20);
        cyc(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule